// File: doc/BRIEF.md
# Analog and Power Register Window

This block decodes a 64 KiB register window that carries two banks of 32-bit control registers and one fixed identification word. A single request port accepts a read or a write per cycle. The decoder selects the sub-region that owns the address and forwards the access to it. It returns the read data one cycle later, with the same latency for every sub-region.

The larger bank holds the clock-synthesizer control words. Its slots come out of reset with fixed settings, and the synthesizer control slots always report their lock flag as set. The smaller bank is a plain scratch area for power controls and clears to zero. Each register occupies a 16-byte slot. The address nibble inside the slot selects one of four update operations, so software can set, clear or flip individual bits without a read-modify-write sequence. The identification word sits on top of one slot of the larger bank and takes priority over it. Writes to that word are refused and flagged.

Top module: `rcw_window`

## Requirements
- R1: Every request with `req_valid` high produces exactly one response with `rsp_valid` high on the following cycle. No response appears in any other cycle. A write response carries `rsp_rdata` = 0. After reset, `rsp_valid`, `rsp_wr_err` and `rsp_rdata` are 0.
- R2: The synthesizer bank has slot i at byte address 0x60 + 16*i, for i from 0 to 127. The power bank has slot k at 0x200 + 16*k, for k from 0 to 15. In the overlap, the power bank takes precedence over the synthesizer bank.
- R3: For a bank slot, address bits [3:2] select the write operation: 0 replaces the value, 1 ORs in the data, 2 clears the bits that are 1 in the data, and 3 XORs with the data. A read through any of the four aliases returns the slot's current value.
- R4: Addresses 0x800 to 0x803 belong only to the identification word and never reach synthesizer slot 122. The other aliases of that slot (0x804, 0x808, 0x80C) still reach slot 122.
- R5: A read of 0x800 returns 0x00720010, which is code 0x720000 with revision 0x10. A write to 0x800 leaves the word unchanged and raises `rsp_wr_err` on its response. No other access raises `rsp_wr_err`.
- R6: After reset the power bank reads zero everywhere. The synthesizer bank loads these values: slot 0 0x80002042, 1 0x8060302C, 2 0x06AAAC4D, 3 0x100003EC, 5 0x80002000, 6 0xD2605A56, 7 0xD2525216, 8 0x80001FC0, 9 0x8001301B, 10 0x05F5E100, 11 0x2964619C, 13 0x8008201B, 14 0x0000F699, 15 0x000F4240, 17 0x80000000. Every other slot loads 0.
- R7: In synthesizer slots 0, 1, 5, 6, 7, 8, 9, 13 and 17, bit 31 (lock) reads 1 after any write operation. In all other slots, bit 31 is ordinary storage.
- R8: An access whose address bits [1:0] are not 0 reads 0, changes no register, and does not raise `rsp_wr_err`.
- R9: Addresses below 0x60, or at 0x860 and above, read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| rsp_wr_err | output | 1 | The responded write targeted the identification word |

## Verification
The bench attacks the overlap at 0x800. A decoder with the wrong priority would let a write land in slot 122, or would return slot data instead of the identification code. A decoder that claimed the whole slot would cut off the 0x804 to 0x80C aliases. The bench drives clear and toggle operations at the lock bit. A design that forced the lock bit only at reset would show it dropping to 0. The bench also probes misaligned and unmapped addresses, which would otherwise alias onto a real slot and corrupt it. Finally, it checks that the error flag fires only for the one refused write.

// File: rtl/rcw_pkg.sv
package rcw_pkg;

   typedef enum logic [1:0] {
      OP_WRITE  = 2'd0,
      OP_SET    = 2'd1,
      OP_CLEAR  = 2'd2,
      OP_TOGGLE = 2'd3
   } bitop_e;

   typedef enum logic [1:0] {
      HIT_NONE = 2'd0,
      HIT_ANA  = 2'd1,
      HIT_PMU  = 2'd2,
      HIT_ID   = 2'd3
   } hit_e;

   localparam int          WORD_W       = 32;
   localparam int          SLOT_BYTES   = 16;
   localparam int          LOCK_BIT     = 31;
   localparam logic [31:0] ID_BASE_CODE = 32'h0072_0000;
   localparam logic [31:0] ID_REVISION  = 32'h0000_0010;

   // Power-up settings of the synthesizer bank, by slot.
   function automatic logic [31:0] pll_init_value(input int slot);
      logic [31:0] v;
      case (slot)
         0:       v = 32'h0000_2042;
         1:       v = 32'h0060_302C;
         2:       v = 32'h06AA_AC4D;
         3:       v = 32'h1000_03EC;
         5:       v = 32'h0000_2000;
         6:       v = 32'h5260_5A56;
         7:       v = 32'h5252_5216;
         8:       v = 32'h0000_1FC0;
         9:       v = 32'h0001_301B;
         10:      v = 32'h05F5_E100;
         11:      v = 32'h2964_619C;
         13:      v = 32'h0008_201B;
         14:      v = 32'h0000_F699;
         15:      v = 32'h000F_4240;
         default: v = 32'h0;
      endcase
      return v;
   endfunction

   // Slots whose lock flag is held at 1.
   function automatic logic pll_has_lock(input int slot);
      logic r;
      case (slot)
         0, 1, 5, 6, 7, 8, 9, 13, 17: r = 1'b1;
         default:                     r = 1'b0;
      endcase
      return r;
   endfunction

   function automatic logic [31:0] apply_bitop(input bitop_e op,
                                               input logic [31:0] cur,
                                               input logic [31:0] wd);
      logic [31:0] n;
      case (op)
         OP_WRITE:  n = wd;
         OP_SET:    n = cur | wd;
         OP_CLEAR:  n = cur & ~wd;
         default:   n = cur ^ wd;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/rcw_decode.sv
module rcw_decode
   import rcw_pkg::*;
#(
   parameter int AW       = 16,
   parameter int ANA_BASE = 'h60,
   parameter int ANA_REGS = 128,
   parameter int PMU_BASE = 'h200,
   parameter int PMU_REGS = 16,
   parameter int ID_ADDR  = 'h800,
   localparam int ANA_IW  = (ANA_REGS > 1) ? $clog2(ANA_REGS) : 1,
   localparam int PMU_IW  = (PMU_REGS > 1) ? $clog2(PMU_REGS) : 1
)(
   input  logic [AW-1:0]     addr,
   output hit_e              hit,
   output logic [ANA_IW-1:0] ana_idx,
   output logic [PMU_IW-1:0] pmu_idx,
   output bitop_e            op
);
   localparam logic [AW:0]   ANA_LO  = (AW+1)'(ANA_BASE);
   localparam logic [AW:0]   ANA_HI  = (AW+1)'(ANA_BASE + ANA_REGS * SLOT_BYTES);
   localparam logic [AW:0]   PMU_LO  = (AW+1)'(PMU_BASE);
   localparam logic [AW:0]   PMU_HI  = (AW+1)'(PMU_BASE + PMU_REGS * SLOT_BYTES);
   localparam logic [AW-3:0] ID_WORD = (AW-2)'(ID_ADDR / 4);

   logic [AW:0] a_ext;
   logic [AW:0] ana_off;
   logic [AW:0] pmu_off;
   logic        aligned;
   logic        in_ana;
   logic        in_pmu;
   logic        is_id;

   always_comb begin
      a_ext   = {1'b0, addr};
      aligned = (addr[1:0] == 2'b00);
      in_ana  = (a_ext >= ANA_LO) && (a_ext < ANA_HI);
      in_pmu  = (a_ext >= PMU_LO) && (a_ext < PMU_HI);
      is_id   = (addr[AW-1:2] == ID_WORD);
      ana_off = a_ext - ANA_LO;
      pmu_off = a_ext - PMU_LO;
      ana_idx = ANA_IW'(ana_off >> 4);
      pmu_idx = PMU_IW'(pmu_off >> 4);
      op      = bitop_e'(addr[3:2]);
      // Priority: identification word, then power bank, then synthesizer bank.
      if (!aligned)    hit = HIT_NONE;
      else if (is_id)  hit = HIT_ID;
      else if (in_pmu) hit = HIT_PMU;
      else if (in_ana) hit = HIT_ANA;
      else             hit = HIT_NONE;
   end

endmodule

// File: rtl/rcw_bank.sv
module rcw_bank
   import rcw_pkg::*;
#(
   parameter int NREGS    = 16,
   parameter bit PLL_INIT = 1'b0,
   localparam int IW      = (NREGS > 1) ? $clog2(NREGS) : 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] idx,
   input  bitop_e        op,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata
);
   logic [NREGS*WORD_W-1:0] flat;

   for (genvar s = 0; s < NREGS; s++) begin : g_slot
      localparam logic        LOCKED    = PLL_INIT ? pll_has_lock(s) : 1'b0;
      localparam logic [31:0] LOCK_MASK = LOCKED ? (32'h1 << LOCK_BIT) : 32'h0;
      localparam logic [31:0] RST_VAL   = (PLL_INIT ? pll_init_value(s) : 32'h0) | LOCK_MASK;

      logic [31:0] q;
      logic        hit_me;

      assign hit_me = wr_en && (idx == IW'(s));

      if (LOCKED) begin : g_locked
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= RST_VAL;
            else if (hit_me) q <= apply_bitop(op, q, wdata) | LOCK_MASK;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q <= RST_VAL;
            else if (hit_me) q <= apply_bitop(op, q, wdata);
         end
      end

      assign flat[s*WORD_W +: WORD_W] = q;
   end

   assign rdata = flat[int'(idx)*WORD_W +: WORD_W];

endmodule

// File: rtl/rcw_window.sv
module rcw_window
   import rcw_pkg::*;
#(
   parameter int AW       = 16,
   parameter int ANA_BASE = 'h60,
   parameter int ANA_REGS = 128,
   parameter int PMU_BASE = 'h200,
   parameter int PMU_REGS = 16,
   parameter int ID_ADDR  = 'h800
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [15:0]   req_addr,
   input  logic [31:0]   req_wdata,
   output logic          rsp_valid,
   output logic [31:0]   rsp_rdata,
   output logic          rsp_wr_err
);
   localparam int          ANA_IW  = (ANA_REGS > 1) ? $clog2(ANA_REGS) : 1;
   localparam int          PMU_IW  = (PMU_REGS > 1) ? $clog2(PMU_REGS) : 1;
   localparam logic [31:0] ID_WORD = ID_BASE_CODE | ID_REVISION;

   if (AW != 16) begin : g_bad_aw
      $error("rcw_window: AW must match the 16-bit address port");
   end
   if ((ANA_BASE % SLOT_BYTES) != 0 || (PMU_BASE % SLOT_BYTES) != 0) begin : g_bad_base
      $error("rcw_window: bank bases must be 16-byte aligned");
   end
   if ((ID_ADDR % 4) != 0) begin : g_bad_id
      $error("rcw_window: identification address must be word aligned");
   end
   if (ANA_BASE + ANA_REGS * SLOT_BYTES > (1 << AW) ||
       PMU_BASE + PMU_REGS * SLOT_BYTES > (1 << AW)) begin : g_bad_span
      $error("rcw_window: a bank runs past the window");
   end

   hit_e              hit;
   logic [ANA_IW-1:0] ana_idx;
   logic [PMU_IW-1:0] pmu_idx;
   bitop_e            op;
   logic [31:0]       ana_rdata;
   logic [31:0]       pmu_rdata;
   logic [31:0]       rd_mux;
   logic              ana_we;
   logic              pmu_we;

   rcw_decode #(
      .AW(AW), .ANA_BASE(ANA_BASE), .ANA_REGS(ANA_REGS),
      .PMU_BASE(PMU_BASE), .PMU_REGS(PMU_REGS), .ID_ADDR(ID_ADDR)
   ) dec_i (
      .addr(req_addr), .hit(hit), .ana_idx(ana_idx), .pmu_idx(pmu_idx), .op(op)
   );

   assign ana_we = req_valid && req_write && (hit == HIT_ANA);
   assign pmu_we = req_valid && req_write && (hit == HIT_PMU);

   rcw_bank #(.NREGS(ANA_REGS), .PLL_INIT(1'b1)) ana_i (
      .clk(clk), .rst_n(rst_n), .wr_en(ana_we), .idx(ana_idx),
      .op(op), .wdata(req_wdata), .rdata(ana_rdata)
   );

   rcw_bank #(.NREGS(PMU_REGS), .PLL_INIT(1'b0)) pmu_i (
      .clk(clk), .rst_n(rst_n), .wr_en(pmu_we), .idx(pmu_idx),
      .op(op), .wdata(req_wdata), .rdata(pmu_rdata)
   );

   always_comb begin
      case (hit)
         HIT_ANA: rd_mux = ana_rdata;
         HIT_PMU: rd_mux = pmu_rdata;
         HIT_ID:  rd_mux = ID_WORD;
         default: rd_mux = 32'h0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_rdata  <= 32'h0;
         rsp_wr_err <= 1'b0;
      end else begin
         rsp_valid  <= req_valid;
         rsp_rdata  <= (req_valid && !req_write) ? rd_mux : 32'h0;
         rsp_wr_err <= req_valid && req_write && (hit == HIT_ID);
      end
   end

endmodule

// File: rtl/rcw_window_chk.sv
module rcw_window_chk
   import rcw_pkg::*;
#(
   parameter int AW       = 16,
   parameter int ANA_BASE = 'h60,
   parameter int ID_ADDR  = 'h800
)(
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_write,
   input logic [AW-1:0] req_addr,
   input logic          rsp_valid,
   input logic [31:0]   rsp_rdata,
   input logic          rsp_wr_err
);
   localparam logic [AW-1:0] ID_A    = AW'(ID_ADDR);
   localparam logic [AW-1:0] ANA_A   = AW'(ANA_BASE);
   localparam logic [31:0]   ID_WORD = ID_BASE_CODE | ID_REVISION;

   assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   assert_write_rdata_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> (rsp_rdata == 32'h0));

   assert_id_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == ID_A) |=> (rsp_rdata == ID_WORD));

   assert_id_write_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_addr == ID_A) |=> rsp_wr_err);

   assert_err_only_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write && req_addr == ID_A) |=> !rsp_wr_err);

   assert_lock_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr == ANA_A) |=> rsp_rdata[LOCK_BIT]);

   assert_unaligned_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr[1:0] != 2'b00) |=> (rsp_rdata == 32'h0));

   assert_unmapped_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_addr < ANA_A) |=> (rsp_rdata == 32'h0));

endmodule

bind rcw_window rcw_window_chk #(
   .AW(AW), .ANA_BASE(ANA_BASE), .ID_ADDR(ID_ADDR)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
   .rsp_wr_err(rsp_wr_err)
);

// File: tb/rcw_window_tb_top.sv
module rcw_window_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [15:0] req_addr = 16'h0;
   logic [31:0] req_wdata = 32'h0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        rsp_wr_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] q_rdata[$];
   logic        q_err[$];
   string       q_tag[$];

   always #5 clk = ~clk;

   rcw_window dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .rsp_wr_err(rsp_wr_err)
   );

   task automatic access(input logic wr, input logic [15:0] a, input logic [31:0] d,
                         input logic [31:0] exp_rd, input logic exp_err, input string tag);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      q_rdata.push_back(exp_rd);
      q_err.push_back(exp_err);
      q_tag.push_back(tag);
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] exp_rd, input string tag);
      access(1'b0, a, 32'h0, exp_rd, 1'b0, tag);
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic exp_err,
                     input string tag);
      access(1'b1, a, d, 32'h0, exp_err, tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
         req_write = 1'b0;
      end
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // Monitor: compare each response against the scoreboard.
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         checks++;
         if (q_rdata.size() == 0) begin
            errors++;
            $display("FAIL R1 unexpected response rdata %h err %b expected none",
                     rsp_rdata, rsp_wr_err);
         end else begin
            automatic logic [31:0] e_rd  = q_rdata.pop_front();
            automatic logic        e_err = q_err.pop_front();
            automatic string       tag   = q_tag.pop_front();
            if (rsp_rdata !== e_rd || rsp_wr_err !== e_err) begin
               errors++;
               $display("FAIL %s rdata %h err %b expected rdata %h err %b",
                        tag, rsp_rdata, rsp_wr_err, e_rd, e_err);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0 || rsp_wr_err !== 1'b0 || rsp_rdata !== 32'h0) begin
         errors++;
         $display("FAIL R1 reset state valid %b err %b rdata %h expected 0 0 0",
                  rsp_valid, rsp_wr_err, rsp_rdata);
      end
      rst_n = 1'b1;
      idle(2);

      // R6 reset values
      rd(16'h0060, 32'h8000_2042, "R6 slot0");
      rd(16'h0070, 32'h8060_302C, "R6 slot1");
      rd(16'h0080, 32'h06AA_AC4D, "R6 slot2");
      rd(16'h00C0, 32'hD260_5A56, "R6 slot6");
      rd(16'h0110, 32'h2964_619C, "R6 slot11");
      rd(16'h0150, 32'h000F_4240, "R6 slot15");
      rd(16'h0170, 32'h8000_0000, "R6 slot17");
      rd(16'h01A0, 32'h0,         "R6 slot20");
      rd(16'h0200, 32'h0,         "R6 power slot0");
      rd(16'h02F0, 32'h0,         "R6 power slot15");
      idle(1);

      // R3 aliases on synthesizer slot 20
      wr(16'h01A0, 32'h0000_F0F0, 1'b0, "R3 write");
      rd(16'h01A4, 32'h0000_F0F0, "R3 read via set alias");
      wr(16'h01A4, 32'h0F00_0000, 1'b0, "R3 set");
      rd(16'h01A0, 32'h0F00_F0F0, "R3 after set");
      wr(16'h01A8, 32'h0000_00F0, 1'b0, "R3 clear");
      rd(16'h01AC, 32'h0F00_F000, "R3 after clear");
      wr(16'h01AC, 32'hFF00_00FF, 1'b0, "R3 toggle");
      rd(16'h01A0, 32'hF000_F0FF, "R3 after toggle");

      // R2 power bank placement
      wr(16'h0230, 32'h1234_5678, 1'b0, "R2 power write");
      rd(16'h0230, 32'h1234_5678, "R2 power read");
      rd(16'h0220, 32'h0,         "R2 power neighbour");
      wr(16'h02F4, 32'h0000_0001, 1'b0, "R2 power set last slot");
      rd(16'h02F0, 32'h0000_0001, "R2 power last slot");
      rd(16'h0850, 32'h0,         "R2 synth last slot");

      // R7 lock bit
      wr(16'h0060, 32'h0,         1'b0, "R7 write zero");
      rd(16'h0060, 32'h8000_0000, "R7 lock after write");
      wr(16'h0068, 32'h8000_0000, 1'b0, "R7 clear lock");
      rd(16'h0060, 32'h8000_0000, "R7 lock after clear");
      wr(16'h006C, 32'h8000_0001, 1'b0, "R7 toggle lock");
      rd(16'h0060, 32'h8000_0001, "R7 lock after toggle");
      wr(16'h0080, 32'h8000_0000, 1'b0, "R7 unlocked write");
      rd(16'h0080, 32'h8000_0000, "R7 unlocked bit31 set");
      wr(16'h0088, 32'h8000_0000, 1'b0, "R7 unlocked clear");
      rd(16'h0080, 32'h0,         "R7 unlocked bit31 cleared");

      // R5 identification word
      rd(16'h0800, 32'h0072_0010, "R5 id read");
      wr(16'h0800, 32'h0,         1'b1, "R5 id write flagged");
      rd(16'h0800, 32'h0072_0010, "R5 id unchanged");

      // R4 overlap with slot 122
      rd(16'h0808, 32'h0,         "R4 slot122 reset");
      wr(16'h0804, 32'h0000_00A5, 1'b0, "R4 set via 0x804");
      rd(16'h080C, 32'h0000_00A5, "R4 slot122 via toggle alias");
      rd(16'h0800, 32'h0072_0010, "R4 id still wins");
      wr(16'h0800, 32'hFFFF_FFFF, 1'b1, "R4 id write");
      rd(16'h0808, 32'h0000_00A5, "R4 slot122 untouched by id write");

      // R8 misaligned
      wr(16'h01A2, 32'hFFFF_FFFF, 1'b0, "R8 misaligned write");
      rd(16'h01A0, 32'hF000_F0FF, "R8 slot unchanged");
      rd(16'h01A1, 32'h0,         "R8 misaligned read");
      rd(16'h0802, 32'h0,         "R8 misaligned id read");
      wr(16'h0801, 32'h0,         1'b0, "R8 misaligned id write no flag");

      // R9 unmapped
      rd(16'h0000, 32'h0,         "R9 read zero page");
      wr(16'h0050, 32'h0000_DEAD, 1'b0, "R9 write below");
      rd(16'h0050, 32'h0,         "R9 read below");
      wr(16'h0860, 32'h0000_BEEF, 1'b0, "R9 write above");
      rd(16'h0860, 32'h0,         "R9 read above");
      rd(16'hFFF0, 32'h0,         "R9 read top");

      idle(4);
      checks++;
      if (q_rdata.size() != 0 || rsp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 drain pending %0d valid %b expected 0 0",
                  q_rdata.size(), rsp_valid);
      end
      done = 1'b1;
      summary();
      $finish;
   end

endmodule